// File: doc/BRIEF.md
# DCC half-bit timing decoder

This block recovers bits from a model-railway track signal in which each bit is two half-periods of equal length. A short half-period stands for a one and a long one stands for a zero. The raw track level first passes through a two-flop synchroniser. Every transition, rising or falling, then ends one half-period. The time since the previous transition is counted in microsecond ticks. A free-running prescaler makes one tick for every `TICK_DIV` system clocks.

Each measured half-period is sorted into one of three classes: one, zero or invalid. Two consecutive halves of the same class make one bit, which is reported with a single-cycle `bit_valid` strobe and the value on `bit_value`. An invalid half raises a single-cycle `bit_error` strobe and empties the pairing stage. The downstream packet framer uses these strobes, and does its own preamble search and byte assembly.

Top module: `dcc_halfbit_decoder`

## Requirements
- R1: After reset `bit_valid`, `bit_value` and `bit_error` are 0 and the pairing stage is empty. The first transition after reset only starts timing and yields no strobe.
- R2: Both rising and falling transitions end a half-period. Its length is the number of ticks between the two transitions, and one tick occurs every `TICK_DIV` clocks (default 8), so edges `8*N` clocks apart measure exactly N.
- R3: A half-period of `ONE_MIN` to `ONE_MAX` ticks, both limits included (defaults 52 and 64), is of class one.
- R4: A half-period of `ZERO_MIN` ticks (default 90) or more is of class zero and raises no error.
- R5: A half-period shorter than `ONE_MIN` ticks raises `bit_error` for one cycle.
- R6: A half-period longer than `ONE_MAX` and shorter than `ZERO_MIN` ticks raises `bit_error` for one cycle.
- R7: After an error the pairing stage is empty, so the next valid half counts as the first half of a new bit.
- R8: Two consecutive halves of the same class give one `bit_valid` pulse. `bit_value` is 1 for a pair of ones and 0 for a pair of zeros.
- R9: When the second half differs in class from the first, no strobe is raised. The earlier half is dropped and the later half becomes the first half of the next bit.
- R10: The period counter saturates at `2**CNT_W-1` ticks and never wraps. A saturated period is of class zero, and a steady line produces no strobe.
- R11: `bit_valid` and `bit_error` are never high together. Each is a one-cycle pulse that rises three clocks after the track input changes: two synchroniser stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| track_in | input | 1 | Asynchronous digital track level |
| bit_valid | output | 1 | One-cycle strobe: a bit was recovered |
| bit_value | output | 1 | Value of the last recovered bit |
| bit_error | output | 1 | One-cycle strobe: a half-period fell outside both windows |

## Verification
Some checks hold on every cycle. The measured length must map to the right error response on the next cycle: a short or mid-gap length must raise `bit_error`, and a long length must not. The counter must stay pinned at its maximum until an edge arrives. The two output strobes must be exclusive and may only follow a measured half-period. Other behaviour depends on a history of several half-periods and is shown only by the bench's scenarios. This includes pairing and its value, dropping a mismatched half, clearing after an error or a reset, the exact window limits and the three-cycle latency.

// File: rtl/dcc_hb_pkg.sv
package dcc_hb_pkg;

  typedef enum logic [1:0] {
    HC_ONE  = 2'd0,
    HC_ZERO = 2'd1,
    HC_BAD  = 2'd2
  } half_class_t;

  // Sort a measured half-period length into its class.
  function automatic half_class_t dcc_classify(input logic [31:0] len,
                                               input int unsigned one_lo,
                                               input int unsigned one_hi,
                                               input int unsigned zero_lo);
    if (len >= zero_lo)
      return HC_ZERO;
    else if (len >= one_lo && len <= one_hi)
      return HC_ONE;
    else
      return HC_BAD;
  endfunction

endpackage

// File: rtl/dcc_tick_gen.sv
module dcc_tick_gen #(
  parameter int unsigned TICK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      div_q <= '0;
    else if (div_q == LAST)
      div_q <= '0;
    else
      div_q <= div_q + DW'(1);
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/dcc_sync_edge.sv
module dcc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_seen
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  // Any change of the synchronised level, rising or falling.
  assign edge_seen = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/dcc_half_timer.sv
module dcc_half_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             edge_seen,
  output logic             half_stb,
  output logic [CNT_W-1:0] half_len,
  output logic [CNT_W-1:0] cnt_q,
  output logic             armed_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_inc;

  // Ticks in the cycles after the previous edge up to and including this one.
  assign cnt_inc  = (tick && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;
  assign half_len = cnt_inc;
  assign half_stb = edge_seen && armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (edge_seen) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_inc;
    end
  end
endmodule

// File: rtl/dcc_bit_pair.sv
module dcc_bit_pair
  import dcc_hb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        half_stb,
  input  half_class_t half_cls,
  output logic        bit_valid,
  output logic        bit_value,
  output logic        bit_error
);
  logic        have_first_q;
  half_class_t first_cls_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_first_q <= 1'b0;
      first_cls_q  <= HC_ONE;
      bit_valid    <= 1'b0;
      bit_value    <= 1'b0;
      bit_error    <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      bit_error <= 1'b0;
      if (half_stb) begin
        if (half_cls == HC_BAD) begin
          bit_error    <= 1'b1;
          have_first_q <= 1'b0;
        end else if (!have_first_q) begin
          have_first_q <= 1'b1;
          first_cls_q  <= half_cls;
        end else if (first_cls_q == half_cls) begin
          bit_valid    <= 1'b1;
          bit_value    <= (half_cls == HC_ONE);
          have_first_q <= 1'b0;
        end else begin
          // Halves disagree: keep the newer half as the start of a bit.
          first_cls_q  <= half_cls;
        end
      end
    end
  end
endmodule

// File: rtl/dcc_halfbit_decoder.sv
module dcc_halfbit_decoder
  import dcc_hb_pkg::*;
#(
  parameter int unsigned TICK_DIV = 8,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned ONE_MIN  = 52,
  parameter int unsigned ONE_MAX  = 64,
  parameter int unsigned ZERO_MIN = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic track_in,
  output logic bit_valid,
  output logic bit_value,
  output logic bit_error
);
  logic             tick;
  logic             edge_seen;
  logic             half_stb;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_armed;
  half_class_t      half_cls;

  dcc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  dcc_sync_edge #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (track_in),
    .edge_seen(edge_seen)
  );

  dcc_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .edge_seen(edge_seen),
    .half_stb (half_stb),
    .half_len (half_len),
    .cnt_q    (tmr_cnt),
    .armed_q  (tmr_armed)
  );

  assign half_cls = dcc_classify(32'(half_len), ONE_MIN, ONE_MAX, ZERO_MIN);

  dcc_bit_pair u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_stb (half_stb),
    .half_cls (half_cls),
    .bit_valid(bit_valid),
    .bit_value(bit_value),
    .bit_error(bit_error)
  );
endmodule

// File: rtl/dcc_halfbit_checker.sv
module dcc_halfbit_checker #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned ONE_MIN  = 52,
  parameter int unsigned ONE_MAX  = 64,
  parameter int unsigned ZERO_MIN = 90
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_seen,
  input logic             half_stb,
  input logic [CNT_W-1:0] half_len,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             bit_valid,
  input logic             bit_error
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R5
  short_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_stb && 32'(half_len) < ONE_MIN) |=> bit_error);

  // R6
  gap_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_stb && 32'(half_len) > ONE_MAX && 32'(half_len) < ZERO_MIN) |=> bit_error);

  // R4
  zero_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_stb && 32'(half_len) >= ZERO_MIN) |=> !bit_error);

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_cnt == CNT_MAX && !edge_seen) |=> tmr_cnt == CNT_MAX);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && bit_error));

  // R11
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid || bit_error) |-> $past(half_stb));
endmodule

bind dcc_halfbit_decoder dcc_halfbit_checker #(
  .CNT_W   (CNT_W),
  .ONE_MIN (ONE_MIN),
  .ONE_MAX (ONE_MAX),
  .ZERO_MIN(ZERO_MIN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .edge_seen(edge_seen),
  .half_stb (half_stb),
  .half_len (half_len),
  .tmr_cnt  (tmr_cnt),
  .bit_valid(bit_valid),
  .bit_error(bit_error)
);

// File: tb/dcc_halfbit_decoder_test.sv
`timescale 1ns/1ps
module dcc_halfbit_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trk = 1'b0;
  logic bit_valid, bit_value, bit_error;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dcc_halfbit_decoder uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .track_in (trk),
    .bit_valid(bit_valid),
    .bit_value(bit_value),
    .bit_error(bit_error)
  );

  // Event codes: 0 none, 1 bit zero, 2 bit one, 3 error.
  // Entry: {length in ticks [23:12], expected event [11:8], requirement [7:0]}
  localparam int NV = 25;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {12'd58,  4'd0, 8'd3},  // R3 first one half
    {12'd58,  4'd2, 8'd8},  // R8 pair of ones
    {12'd100, 4'd0, 8'd4},  // R4
    {12'd100, 4'd1, 8'd8},  // R8 pair of zeros
    {12'd52,  4'd0, 8'd3},  // R3 lower limit
    {12'd64,  4'd2, 8'd3},  // R3 upper limit
    {12'd90,  4'd0, 8'd4},  // R4 lower limit
    {12'd300, 4'd1, 8'd10}, // R10 saturated period
    {12'd58,  4'd0, 8'd9},
    {12'd100, 4'd0, 8'd9},  // R9 mismatch, no strobe
    {12'd95,  4'd1, 8'd9},  // R9 newer half re-seeds the pair
    {12'd51,  4'd3, 8'd5},  // R5 just short
    {12'd58,  4'd0, 8'd7},
    {12'd65,  4'd3, 8'd6},  // R6 just long
    {12'd60,  4'd0, 8'd7},  // R7 pairing empty after error
    {12'd60,  4'd2, 8'd7},
    {12'd89,  4'd3, 8'd6},  // R6 just below zero window
    {12'd58,  4'd0, 8'd7},
    {12'd77,  4'd3, 8'd6},  // R6 mid gap
    {12'd56,  4'd0, 8'd7},  // R7
    {12'd56,  4'd2, 8'd2},  // R2 both edge directions timed
    {12'd100, 4'd0, 8'd7},
    {12'd40,  4'd3, 8'd5},  // R5
    {12'd100, 4'd0, 8'd7},  // R7 stored zero was dropped
    {12'd100, 4'd1, 8'd8}
  };

  // Wait n ticks since the last transition, toggle, then watch the strobes.
  // R11: the strobe must be seen on the third falling clock edge after the toggle.
  task automatic drive_half(input int n, input int exp, input int req);
    int stray = 0;
    int got = 0;
    int idx = 0;
    repeat (n * 8 - 6) begin
      @(negedge clk);
      if (bit_valid || bit_error) stray++;
    end
    trk = ~trk;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (bit_error) begin got = 3; idx = i; end
      else if (bit_valid) begin got = bit_value ? 2 : 1; idx = i; end
    end
    checks++;
    if (stray != 0 || got != exp || (exp != 0 && idx != 3)) begin
      fails++;
      $display("FAIL R%0d: half of %0d ticks gave event %0d at edge+%0d (stray %0d), expected event %0d at edge+3",
               req, n, got, idx, stray, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    trk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_idle(input int req);
    checks++;
    if (bit_valid || bit_value || bit_error) begin
      fails++;
      $display("FAIL R%0d: outputs after reset %b%b%b, expected 000",
               req, bit_valid, bit_value, bit_error);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle(1);            // R1 reset state
    drive_half(20, 0, 1);     // R1 first edge only arms
    for (int v = 0; v < NV; v++)
      drive_half(int'(VEC[v][23:12]), int'(VEC[v][11:8]), int'(VEC[v][7:0]));

    // R10: long steady line, no strobe, saturates into a zero half
    drive_half(625, 0, 10);
    drive_half(100, 1, 10);

    // R1: reset in the middle of a pair empties the pairing stage
    drive_half(58, 0, 1);
    do_reset();
    @(negedge clk);
    check_idle(1);
    drive_half(10, 0, 1);
    drive_half(58, 0, 1);
    drive_half(58, 2, 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end
endmodule